// File: doc/BRIEF.md
# Character-Cell Text Overlay Engine

This block places a rectangular grid of text characters on top of an incoming pixel stream. A host fills a cell memory with one 16-bit word per character position, holding a character code and a colour attribute. Through a small register set it enables the overlay, picks how many columns and rows are visible, and places the top-left corner of the text window at a pixel position. Two read-only registers report a version number and the largest grid the cell memory can hold.

The video source supplies the current pixel coordinate with each pixel, along with data-enable, both syncs and the pixel colour. For each active pixel inside the window, the engine finds the cell under the pixel and reads its word. It forms the glyph row for the character code and shows the foreground or the background palette colour in place of the incoming pixel. Sync and data-enable travel through a delay of the same length, so the replaced colour stays in line with them. Video timing generation, clocking and the display transmitter are outside this block.

Top module: `glyph_overlay`

## Requirements
- R1: After reset, out_de, out_hs, out_vs and out_rgb are 0, the overlay is disabled, and the size, X-origin and Y-origin registers read 0x1F0F, 0x007F and 0x005F.
- R2: The cell memory holds 32x16 = 512 words. The word for column c, row r sits at address r*32 + c, with the character code in bits 15:8 and the attribute in bits 7:0.
- R3: A write with mem_addr of 512 or more changes no cell.
- R4: Select 0 reads the version as major*100 + minor (default 1 and 5, giving 0x0069). Select 1 reads the capacity as (columns-1) in bits 13:8 and (rows-1) in bits 4:0, which is 0x1F0F.
- R5: Select 2 is control, with bit 0 as the overlay enable, and reads back only that bit. Select 3 is size, with (visible columns-1) in bits 15:8 and (visible rows-1) in bits 7:0. Selects 4 and 5 are the X and Y origins in pixels. Each of these reads back the value last written.
- R6: Let dx = x - X-origin and dy = y - Y-origin. A pixel is in the window when dx >= 0, dy >= 0, dx < 8*C and dy < 16*R. Its cell is column dx/8, row dy/16, its glyph line is dy%16, and its glyph bit is bit 7-(dx%8).
- R7: The glyph line for code k at line g is 0x00 when g is 0 or 15. Otherwise it is k XOR (g*0x11). A set bit shows the palette colour of attribute bits 3:0, and a clear bit shows the palette colour of attribute bits 7:4.
- R8: Palette entry i has a level of 0xFF when i[3] is set and 0x7F otherwise. Red takes the level when i[2] is set, green when i[1] is set, and blue when i[0] is set (out_rgb = {R,G,B}). Each channel is 0 when its bit is clear.
- R9: When the pixel is outside the window, data-enable is low, or the enable bit is clear, out_rgb equals the input pixel colour.
- R10: out_de, out_hs, out_vs and out_rgb show the inputs of exactly 3 clock cycles earlier.
- R11: Size fields larger than the capacity are clamped, so C = min(cols field+1, 32) and R = min(rows field+1, 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_sel (combinational) |
| mem_we | input | 1 | Cell memory write strobe |
| mem_addr | input | 10 | Cell memory write address |
| mem_wdata | input | 16 | Cell word: code 15:8, attribute 7:0 |
| vid_x | input | 12 | Current pixel column |
| vid_y | input | 12 | Current pixel line |
| vid_de | input | 1 | Input data-enable |
| vid_hs | input | 1 | Input horizontal sync |
| vid_vs | input | 1 | Input vertical sync |
| vid_rgb | input | 24 | Input pixel colour |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Overlaid pixel colour |

## Verification
Register reads are combinational, so the bench samples reg_rdata half a cycle after it sets reg_sel. A cell write takes effect at the next rising edge. Every video result is due three rising edges after the pixel is presented. The bench drives a pixel at a falling edge, clears its data-enable and syncs at the next falling edge, and compares all four video outputs at the third falling edge. At the second falling edge it also checks that the sync has not yet appeared, which shows the delay is exactly three cycles and not two.

// File: rtl/glyph_overlay_pkg.sv
package glyph_overlay_pkg;

  typedef enum logic [2:0] {
    SEL_VERSION = 3'd0,
    SEL_FEATURE = 3'd1,
    SEL_CONTROL = 3'd2,
    SEL_SIZE    = 3'd3,
    SEL_XORG    = 3'd4,
    SEL_YORG    = 3'd5
  } reg_sel_e;

  localparam int GLYPH_W = 8;
  localparam int GLYPH_H = 16;

  // Computed font: blank top and bottom lines, pattern elsewhere.
  function automatic logic [7:0] glyph_line(input logic [7:0] code, input logic [3:0] line);
    if (line == 4'd0 || line == 4'd15) return 8'h00;
    return code ^ {line, line};
  endfunction

  // 16-entry palette: bit 3 is intensity, bits 2:0 are R,G,B.
  function automatic logic [23:0] palette_rgb(input logic [3:0] idx);
    logic [7:0] lvl;
    lvl = idx[3] ? 8'hFF : 8'h7F;
    return {idx[2] ? lvl : 8'h00, idx[1] ? lvl : 8'h00, idx[0] ? lvl : 8'h00};
  endfunction

endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
  import glyph_overlay_pkg::*;
#(
  parameter int COLS      = 32,
  parameter int ROWS      = 16,
  parameter int PIX_W     = 12,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 5,
  parameter int XORG_RST  = 127,
  parameter int YORG_RST  = 95
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             ctrl_en,
  output logic [7:0]       size_cols,
  output logic [7:0]       size_rows,
  output logic [PIX_W-1:0] org_x,
  output logic [PIX_W-1:0] org_y
);
  localparam logic [15:0] VERSION_VAL = 16'(VER_MAJOR * 100 + VER_MINOR);
  localparam logic [15:0] FEATURE_VAL = {2'b00, 6'(COLS - 1), 3'b000, 5'(ROWS - 1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      size_cols <= 8'(COLS - 1);
      size_rows <= 8'(ROWS - 1);
      org_x     <= PIX_W'(XORG_RST);
      org_y     <= PIX_W'(YORG_RST);
    end else if (reg_we) begin
      case (reg_sel)
        SEL_CONTROL: ctrl_en <= reg_wdata[0];
        SEL_SIZE: begin
          size_cols <= reg_wdata[15:8];
          size_rows <= reg_wdata[7:0];
        end
        SEL_XORG: org_x <= reg_wdata[PIX_W-1:0];
        SEL_YORG: org_y <= reg_wdata[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_VERSION: reg_rdata = VERSION_VAL;
      SEL_FEATURE: reg_rdata = FEATURE_VAL;
      SEL_CONTROL: reg_rdata = {15'd0, ctrl_en};
      SEL_SIZE:    reg_rdata = {size_cols, size_rows};
      SEL_XORG:    reg_rdata = 16'(org_x);
      SEL_YORG:    reg_rdata = 16'(org_y);
      default:     reg_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/ovl_cellmem.sv
module ovl_cellmem #(
  parameter int DEPTH   = 512,
  parameter int HOST_AW = 10,
  localparam int MEM_AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic [15:0]        wr_data,
  input  logic [MEM_AW-1:0]  rd_addr,
  output logic [15:0]        rd_data,
  output logic               wr_fire
);
  logic [15:0] cells [DEPTH];

  // Writes at or past the capacity are dropped rather than wrapped.
  assign wr_fire = wr_en && (int'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_fire) cells[MEM_AW'(wr_addr)] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 16'd0;
    else        rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/ovl_render.sv
module ovl_render
  import glyph_overlay_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int ROWS  = 16,
  parameter int PIX_W = 12,
  localparam int MEM_AW = $clog2(COLS * ROWS),
  localparam int COL_AW = $clog2(COLS),
  localparam int ROW_AW = $clog2(ROWS),
  localparam int CW     = COL_AW + 1,
  localparam int RW     = ROW_AW + 1,
  localparam int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [7:0]        size_cols,
  input  logic [7:0]        size_rows,
  input  logic [PIX_W-1:0]  org_x,
  input  logic [PIX_W-1:0]  org_y,
  input  logic [PIX_W-1:0]  vid_x,
  input  logic [PIX_W-1:0]  vid_y,
  input  logic              vid_de,
  input  logic              vid_hs,
  input  logic              vid_vs,
  input  logic [23:0]       vid_rgb,
  output logic [MEM_AW-1:0] cell_raddr,
  input  logic [15:0]       cell_rdata,
  output logic              hit_s0,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs,
  output logic [23:0]       out_rgb
);
  // ---------------- stage 0: window test and cell address
  logic [CW-1:0]    eff_cols;
  logic [RW-1:0]    eff_rows;
  logic [PIX_W:0]   span_x, span_y;
  logic [PIX_W-1:0] rel_x, rel_y;
  logic             x_ok, y_ok;

  assign eff_cols = (size_cols >= 8'(COLS - 1)) ? CW'(COLS) : CW'({1'b0, size_cols} + 9'd1);
  assign eff_rows = (size_rows >= 8'(ROWS - 1)) ? RW'(ROWS) : RW'({1'b0, size_rows} + 9'd1);
  assign span_x   = {{(PIX_W + 1 - CW - 3){1'b0}}, eff_cols, 3'b000};
  assign span_y   = {{(PIX_W + 1 - RW - 4){1'b0}}, eff_rows, 4'b0000};
  assign rel_x    = vid_x - org_x;
  assign rel_y    = vid_y - org_y;
  assign x_ok     = (vid_x >= org_x) && ({1'b0, rel_x} < span_x);
  assign y_ok     = (vid_y >= org_y) && ({1'b0, rel_y} < span_y);
  assign hit_s0   = vid_de && en && x_ok && y_ok;

  assign cell_raddr = MEM_AW'(int'(rel_y[4 +: ROW_AW]) * COLS + int'(rel_x[3 +: COL_AW]));

  // ---------------- sync delay line, one register per pipeline stage
  logic [2:0] sync_pipe [LAT + 1];
  assign sync_pipe[0] = {vid_de, vid_hs, vid_vs};
  for (genvar i = 0; i < LAT; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_pipe[i + 1] <= 3'b000;
      else        sync_pipe[i + 1] <= sync_pipe[i];
    end
  end
  assign {out_de, out_hs, out_vs} = sync_pipe[LAT];

  // ---------------- stage 1: cell word arrives, glyph lookup
  logic        s1_hit;
  logic [3:0]  s1_line;
  logic [2:0]  s1_px;
  logic [23:0] s1_rgb;
  logic [7:0]  s1_bits;
  logic        s1_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hit <= 1'b0; s1_line <= 4'd0; s1_px <= 3'd0; s1_rgb <= 24'd0;
    end else begin
      s1_hit  <= hit_s0;
      s1_line <= rel_y[3:0];
      s1_px   <= rel_x[2:0];
      s1_rgb  <= vid_rgb;
    end
  end

  assign s1_bits = glyph_line(cell_rdata[15:8], s1_line);
  assign s1_on   = s1_bits[3'd7 - s1_px];

  // ---------------- stage 2: palette select
  logic        s2_hit, s2_on;
  logic [7:0]  s2_attr;
  logic [23:0] s2_rgb, s2_color;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_hit <= 1'b0; s2_on <= 1'b0; s2_attr <= 8'd0; s2_rgb <= 24'd0;
    end else begin
      s2_hit  <= s1_hit;
      s2_on   <= s1_on;
      s2_attr <= cell_rdata[7:0];
      s2_rgb  <= s1_rgb;
    end
  end

  assign s2_color = s2_on ? palette_rgb(s2_attr[3:0]) : palette_rgb(s2_attr[7:4]);

  // ---------------- stage 3: output mux
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_rgb <= 24'd0;
    else        out_rgb <= s2_hit ? s2_color : s2_rgb;
  end
endmodule

// File: rtl/glyph_overlay.sv
module glyph_overlay
  import glyph_overlay_pkg::*;
#(
  parameter int COLS      = 32,
  parameter int ROWS      = 16,
  parameter int PIX_W     = 12,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 5,
  localparam int DEPTH    = COLS * ROWS,
  localparam int MEM_AW   = $clog2(DEPTH),
  localparam int HOST_AW  = MEM_AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               mem_we,
  input  logic [HOST_AW-1:0] mem_addr,
  input  logic [15:0]        mem_wdata,
  input  logic [PIX_W-1:0]   vid_x,
  input  logic [PIX_W-1:0]   vid_y,
  input  logic               vid_de,
  input  logic               vid_hs,
  input  logic               vid_vs,
  input  logic [23:0]        vid_rgb,
  output logic               out_de,
  output logic               out_hs,
  output logic               out_vs,
  output logic [23:0]        out_rgb
);
  logic              ctrl_en;
  logic [7:0]        size_cols, size_rows;
  logic [PIX_W-1:0]  org_x, org_y;
  logic [MEM_AW-1:0] cell_raddr;
  logic [15:0]       cell_rdata;
  logic              cell_wr_fire;
  logic              hit_s0;

  ovl_regs #(
    .COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_en(ctrl_en),
    .size_cols(size_cols), .size_rows(size_rows), .org_x(org_x), .org_y(org_y)
  );

  ovl_cellmem #(.DEPTH(DEPTH), .HOST_AW(HOST_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_we), .wr_addr(mem_addr),
    .wr_data(mem_wdata), .rd_addr(cell_raddr), .rd_data(cell_rdata),
    .wr_fire(cell_wr_fire)
  );

  ovl_render #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_render (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en),
    .size_cols(size_cols), .size_rows(size_rows), .org_x(org_x), .org_y(org_y),
    .vid_x(vid_x), .vid_y(vid_y), .vid_de(vid_de), .vid_hs(vid_hs),
    .vid_vs(vid_vs), .vid_rgb(vid_rgb), .cell_raddr(cell_raddr),
    .cell_rdata(cell_rdata), .hit_s0(hit_s0), .out_de(out_de),
    .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int DEPTH   = 512,
  parameter int HOST_AW = 10,
  parameter int COLS    = 32,
  parameter int ROWS    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vid_de,
  input logic               vid_hs,
  input logic               vid_vs,
  input logic [23:0]        vid_rgb,
  input logic               out_de,
  input logic               out_hs,
  input logic               out_vs,
  input logic [23:0]        out_rgb,
  input logic               mem_we,
  input logic [HOST_AW-1:0] mem_addr,
  input logic               cell_wr_fire,
  input logic [2:0]         reg_sel,
  input logic [15:0]        reg_rdata,
  input logic               hit_s0
);
  logic [1:0] since_rst;
  logic       hist_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign hist_ok = (since_rst == 2'd3);

  // R10: all three control signals leave exactly three cycles late
  a_r10_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> (out_de == $past(vid_de, 3)) && (out_hs == $past(vid_hs, 3)) && (out_vs == $past(vid_vs, 3)));

  // R9: blanked pixels keep their colour
  a_r9_blank_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(vid_de, 3)) |-> out_rgb == $past(vid_rgb, 3));

  // R3: out-of-range writes never reach the array
  a_r3_oob_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && int'(mem_addr) >= DEPTH) |-> !cell_wr_fire);

  // R2: in-range writes always land
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && int'(mem_addr) < DEPTH) |-> cell_wr_fire);

  // R4: capacity register content
  a_r4_feature: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 3'd1) |-> reg_rdata == {2'b00, 6'(COLS - 1), 3'b000, 5'(ROWS - 1)});

  // R9: a window hit only happens for active pixels
  a_r9_hit_needs_de: assert property (@(posedge clk) disable iff (!rst_n)
    hit_s0 |-> vid_de);
endmodule

bind glyph_overlay ovl_checker #(
  .DEPTH(DEPTH), .HOST_AW(HOST_AW), .COLS(COLS), .ROWS(ROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
  .vid_rgb(vid_rgb), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
  .out_rgb(out_rgb), .mem_we(mem_we), .mem_addr(mem_addr),
  .cell_wr_fire(cell_wr_fire), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .hit_s0(hit_s0)
);

// File: tb/glyph_overlay_test.sv
`timescale 1ns/1ps
module glyph_overlay_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mem_we = 1'b0;
  logic [9:0]  mem_addr = 10'd0;
  logic [15:0] mem_wdata = 16'd0;
  logic [11:0] vid_x = 12'd0, vid_y = 12'd0;
  logic        vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
  logic [23:0] vid_rgb = 24'd0;
  logic        out_de, out_hs, out_vs;
  logic [23:0] out_rgb;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  glyph_overlay uut (.*);

  // bench model state
  logic [15:0] ref_mem [512];
  int m_en = 0, m_cols = 31, m_rows = 15, m_ox = 127, m_oy = 95;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_colour(int i);
    int lvl = (i >= 8) ? 255 : 127;
    int r = ((i / 4) % 2) * lvl;
    int g = ((i / 2) % 2) * lvl;
    int b = (i % 2) * lvl;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  function automatic logic [23:0] model_pixel(int x, int y, logic de, logic [23:0] rgb);
    int c = (m_cols + 1 > 32) ? 32 : m_cols + 1;
    int r = (m_rows + 1 > 16) ? 16 : m_rows + 1;
    int dx = x - m_ox;
    int dy = y - m_oy;
    int code, attr, gl, pat, on;
    if (!de || m_en == 0 || dx < 0 || dy < 0 || dx >= c * 8 || dy >= r * 16) return rgb;
    code = int'(ref_mem[(dy / 16) * 32 + dx / 8][15:8]);
    attr = int'(ref_mem[(dy / 16) * 32 + dx / 8][7:0]);
    gl = dy % 16;
    pat = (gl == 0 || gl == 15) ? 0 : (code ^ (gl * 17));
    on = (pat >> (7 - dx % 8)) & 1;
    return model_colour(on != 0 ? attr % 16 : attr / 16);
  endfunction

  task automatic reg_write(logic [2:0] sel, logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic mem_write(int a, logic [15:0] val);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = 10'(a); mem_wdata = val;
    if (a < 512) ref_mem[a] = val;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  // Present one pixel, return outputs three edges later.
  task automatic pixel(string req, int x, int y, logic de, logic hs, logic [23:0] rgb);
    logic [23:0] exp;
    exp = model_pixel(x, y, de, rgb);
    @(negedge clk);
    vid_x = 12'(x); vid_y = 12'(y); vid_de = de; vid_hs = hs; vid_vs = hs; vid_rgb = rgb;
    @(negedge clk);
    vid_de = 1'b0; vid_hs = 1'b0; vid_vs = 1'b0; vid_rgb = 24'h0;
    @(negedge clk);
    if (hs) check("R10 early hs", 32'(out_hs), 32'd0);
    @(negedge clk);
    check({req, " rgb"}, 32'(out_rgb), 32'(exp));
    check("R10 de", 32'(out_de), 32'(de));
    if (hs) begin
      check("R10 hs", 32'(out_hs), 32'd1);
      check("R10 vs", 32'(out_vs), 32'd1);
    end
  endtask

  // {x, y} pixel positions inside and around the default window
  localparam logic [23:0] VEC [14] = '{
    {12'd127, 12'd95},  {12'd126, 12'd95},  {12'd127, 12'd94},
    {12'd382, 12'd350}, {12'd383, 12'd200}, {12'd200, 12'd351},
    {12'd135, 12'd111}, {12'd134, 12'd112}, {12'd200, 12'd150},
    {12'd300, 12'd300}, {12'd250, 12'd97},  {12'd129, 12'd100},
    {12'd377, 12'd340}, {12'd160, 12'd260}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    check("R1 out_de", 32'(out_de), 0);
    check("R1 out_rgb", 32'(out_rgb), 0);
    rst_n = 1'b1;
    reg_read(3'd2, rd); check("R1 control", 32'(rd), 0);
    reg_read(3'd3, rd); check("R1 size", 32'(rd), 32'h1F0F);
    reg_read(3'd4, rd); check("R1 xorg", 32'(rd), 32'h007F);
    reg_read(3'd5, rd); check("R1 yorg", 32'(rd), 32'h005F);
    reg_read(3'd0, rd); check("R4 version", 32'(rd), 32'd105);
    reg_read(3'd1, rd); check("R4 feature", 32'(rd), 32'h1F0F);

    // R2 fill memory: code and attribute derived from address
    for (int a = 0; a < 512; a++)
      mem_write(a, {8'(a) ^ 8'hA5, 4'(a) ^ 4'h3, 4'(a >> 4)});

    // R9 enable clear: inside window still passes through
    pixel("R9 disabled", 200, 150, 1'b1, 1'b0, 24'hABCDEF);

    reg_write(3'd2, 16'hFFFF);
    m_en = 1;
    reg_read(3'd2, rd); check("R5 control bit0 only", 32'(rd), 1);

    // R6 R7 R8 table walk with default window
    for (int i = 0; i < 14; i++)
      pixel("R6 R7 R8 table", int'(VEC[i][23:12]), int'(VEC[i][11:0]), 1'b1, 1'b0,
            24'h102030 + 24'(i));

    // R9 data-enable low inside window, R10 sync alignment
    pixel("R9 de low", 200, 150, 1'b0, 1'b1, 24'h445566);
    pixel("R10 aligned", 140, 120, 1'b1, 1'b1, 24'h000001);

    // R3 out-of-range write must not alias cell 0 (pixel 127,96 reads cell 0)
    mem_write(512, 16'h0000);
    mem_write(1023, 16'hFFFF);
    for (int k = 0; k < 8; k++)
      pixel("R3 oob ignored", 127 + k, 97, 1'b1, 1'b0, 24'h777777);

    // R5 R6 small window moved: 2 columns by 1 row at (10,20)
    reg_write(3'd3, 16'h0100); m_cols = 1; m_rows = 0;
    reg_write(3'd4, 16'd10);   m_ox = 10;
    reg_write(3'd5, 16'd20);   m_oy = 20;
    reg_read(3'd3, rd); check("R5 size readback", 32'(rd), 32'h0100);
    reg_read(3'd4, rd); check("R5 xorg readback", 32'(rd), 10);
    reg_read(3'd5, rd); check("R5 yorg readback", 32'(rd), 20);
    pixel("R6 small in", 25, 21, 1'b1, 1'b0, 24'h111111);
    pixel("R6 small right edge", 26, 21, 1'b1, 1'b0, 24'h222222);
    pixel("R6 small bottom edge", 12, 36, 1'b1, 1'b0, 24'h333333);
    pixel("R6 small glyph", 18, 30, 1'b1, 1'b0, 24'h444444);

    // R11 oversize fields clamp to 32x16
    reg_write(3'd3, 16'hFFFF); m_cols = 255; m_rows = 255;
    pixel("R11 last cell", 265, 275, 1'b1, 1'b0, 24'h555555);
    pixel("R11 past cols", 266, 30, 1'b1, 1'b0, 24'h666666);
    pixel("R11 past rows", 20, 276, 1'b1, 1'b0, 24'h777777);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule